// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Error Status

This block turns an asynchronous serial line into bytes that software can read. A free-running sampling enable, supplied from outside at a multiple of the bit rate (16 by default), drives a framing engine. The engine waits for a falling edge on the line and confirms the start bit at its middle. It then shifts in the data bits least significant first, takes an optional parity bit and checks one or two stop bits. The character length (7 or 8 bits), the parity scheme and the stop-bit count come from a format control register.

When a character completes, the block moves it from the shift register into a holding buffer and evaluates the overrun, parity and framing conditions in that same cycle. A status word reports a buffer-full flag, the three error flags and a summary error flag. Software uses three addresses on a small register port. It reads the buffer, which releases the full flag. It writes the status address, which clears the errors. It writes the control word, whose master enable also wipes every flag when it is turned off.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the control word reads 0x00 and the status word reads 0xE0. Status layout: bit0 buffer full, bit1 overrun, bit2 parity error, bit3 framing error, bit4 summary error, and bits 7:5 unused, which always read 1. Addresses: 0 is the buffer (read), 1 is the status (read, write clears errors), 2 is the control. Control layout: bit0 7-bit characters, bit1 parity enable, bit2 odd parity, bit3 two stop bits, bit6 receive enable, bit7 master enable.
- R2: In 8-bit mode a frame is one low start bit, then 8 data bits LSB first, then the stop bit(s). Each bit lasts OSR sampling ticks and is sampled in its middle. The data lands in the buffer and the buffer-full flag sets.
- R3: In 7-bit mode 7 data bits are taken and the buffer MSB reads 0.
- R4: With parity enabled, a parity bit follows the data and is not stored. The parity error flag sets when the count of ones over data plus parity is odd while even parity is selected (bit2 = 0), or even while odd parity is selected (bit2 = 1).
- R5: A framing error flags when the first stop bit is sampled low. With two stop bits selected, the second stop bit is received but not checked.
- R6: Reading the buffer address clears the buffer-full flag.
- R7: A character that completes while the buffer-full flag is set raises the overrun flag and leaves the buffer contents unchanged.
- R8: The summary error flag equals the OR of the overrun, parity and framing flags.
- R9: Any write to the status address clears the overrun, parity, framing and summary flags and leaves the buffer-full flag as it was.
- R10: Setting the master enable to 0 clears every status flag, including the error flags.
- R11: While the receive enable or the master enable is 0, line activity has no effect and no character is received.
- R12: A low pulse that is gone before the middle of the start bit is treated as noise and starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sampling enable, OSR pulses per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| reg_addr | input | 2 | Register address (0 buffer, 1 status, 2 control) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 releases the buffer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the addressed register, combinational |

## Verification
The bench builds the block with its defaults: 16 samples per bit and an 8-bit buffer. The sampling enable is pulsed on every second clock, so the counters must advance on the enable and not on the clock. Because the 8-bit buffer holds both character lengths, the zero MSB of 7-bit mode can be seen beside full 8-bit data. Sixteen samples per bit leave room for a noise pulse shorter than half a bit, and for frames whose parity or stop bits are deliberately wrong.

// File: rtl/uart_rx_pkg.sv
// Shared definitions for the oversampled serial receiver.
// Assumes an 8-bit register port; data width may not exceed REG_W.
package uart_rx_pkg;

    localparam int REG_W = 8;

    // Register addresses on the software port.
    localparam logic [1:0] ADR_BUF  = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;

    // Format and enable control word.
    typedef struct packed {
        logic       ser_en;
        logic       rx_en;
        logic [1:0] spare;
        logic       stop2;
        logic       par_odd;
        logic       par_en;
        logic       char7;
    } rx_ctrl_t;

    // Framing engine states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5
    } rx_state_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
// Control register: holds character format and enables.
// Assumes writes are single-cycle strobes; resets to all zero (disabled).
module uart_rx_ctrl
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output rx_ctrl_t         ctrl_o
);

    // Capture the written control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_o <= '0;
        else if (wr_i)
            ctrl_o <= rx_ctrl_t'(wdata_i);
    end

    // R1: the control word changes only on a write
    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctrl_o));

endmodule

// File: rtl/uart_rx_frame.sv
// Framing engine: detects a start bit, samples each bit in its middle,
// shifts data LSB first, takes optional parity and one or two stop bits,
// then pulses done for one clock with aligned data and error results.
// Assumes smp_en pulses OSR times per bit and the format is held steady
// for the duration of a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              smp_en,
    input  logic              rxd,
    input  logic              char7,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);

    localparam int CNT_W = $clog2(OSR);
    localparam int HALF  = OSR / 2;
    localparam int BIT_W = $clog2(DATA_W + 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              ferr_q;

    logic              at_mid;
    logic              start_mid;
    logic [BIT_W-1:0]  last_idx;
    logic [DATA_W-1:0] aligned;
    logic              finish;
    logic              fe_now;

    // Decode sampling points, character length and frame completion.
    always_comb begin
        at_mid    = (cnt == CNT_W'(OSR - 1));
        start_mid = (cnt == CNT_W'(HALF - 1));
        last_idx  = char7 ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1);
        aligned   = char7 ? {1'b0, shreg[DATA_W-1:1]} : shreg;
        finish    = smp_en && at_mid &&
                    (((state == ST_STOP1) && !stop2) || (state == ST_STOP2));
        fe_now    = (state == ST_STOP1) ? !rxd : ferr_q;
    end

    // Advance the frame state machine on each sampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            ferr_q  <= 1'b0;
        end else if (smp_en) begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!rxd)
                        state <= ST_START;
                end
                ST_START: begin
                    if (start_mid) begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        state   <= rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_mid) begin
                        cnt     <= '0;
                        shreg   <= {rxd, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == last_idx)
                            state <= par_en ? ST_PAR : ST_STOP1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_mid) begin
                        cnt     <= '0;
                        par_bit <= rxd;
                        state   <= ST_STOP1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP1: begin
                    if (at_mid) begin
                        cnt    <= '0;
                        ferr_q <= !rxd;
                        state  <= stop2 ? ST_STOP2 : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP2: begin
                    if (at_mid) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Present the finished character and its check results for one clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            done_o <= 1'b0;
            data_o <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (finish) begin
                data_o <= aligned;
                perr_o <= par_en && ((^aligned) ^ par_bit ^ par_odd);
                ferr_o <= fe_now;
            end
        end
    end

    // R11: the engine falls back to idle while reception is off
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state == ST_IDLE));

    // R2: a completed character is reported for exactly one clock
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the bit index never passes the character length
    p_bitidx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (bit_idx <= BIT_W'(DATA_W - 1)));

    // R3: a 7-bit character carries a zero MSB
    p_msb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(char7) && $past(run_i)) |-> !data_o[DATA_W-1]);

endmodule

// File: rtl/uart_rx_flags.sv
// Receive buffer and status flags: accepts a finished character into the
// buffer, evaluates overrun, parity and framing at that transfer, keeps
// sticky error flags and a summary flag, and applies software clears.
// Assumes done_i is a single-clock pulse from the framing engine.
module uart_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              rd_buf_i,
    input  logic              wr_stat_i,
    output logic [DATA_W-1:0] buf_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              sum_o
);

    logic accept;
    logic ovr_evt;

    // Decide between a buffer transfer and an overrun.
    always_comb begin
        accept  = done_i && (!full_o || rd_buf_i);
        ovr_evt = done_i && full_o && !rd_buf_i;
    end

    // Load the buffer on a transfer; keep it on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_o <= '0;
        else if (accept)
            buf_o <= data_i;
    end

    // Track buffer-full: set by transfer, cleared by read or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_en_i)
            full_o <= 1'b0;
        else if (accept)
            full_o <= 1'b1;
        else if (rd_buf_i)
            full_o <= 1'b0;
    end

    // Sticky error flags, cleared by a status write or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !ser_en_i) begin
            ovr_o <= 1'b0;
            pe_o  <= 1'b0;
            fe_o  <= 1'b0;
            sum_o <= 1'b0;
        end else begin
            ovr_o <= (ovr_o && !wr_stat_i) || ovr_evt;
            pe_o  <= (pe_o  && !wr_stat_i) || (accept && perr_i);
            fe_o  <= (fe_o  && !wr_stat_i) || (accept && ferr_i);
            sum_o <= (sum_o && !wr_stat_i) || ovr_evt ||
                     (accept && (perr_i || ferr_i));
        end
    end

    // R8: summary flag tracks the OR of the three error flags
    p_sum_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == (ovr_o || pe_o || fe_o));

    // R7: an overrun keeps the old buffer and raises the flag
    p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && done_i && full_o && !rd_buf_i) |=> ($stable(buf_o) && ovr_o));

    // R10: disable wipes every flag
    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en_i |=> (!full_o && !ovr_o && !pe_o && !fe_o && !sum_o));

    // R6: a buffer read without a new character releases the buffer
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && rd_buf_i && !done_i) |=> !full_o);

    // R9: a status write leaves buffer-full untouched
    p_wr_keeps_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en_i && wr_stat_i && !done_i && !rd_buf_i) |=> $stable(full_o));

endmodule

// File: rtl/uart_rx_stat.sv
// Top of the serial receiver: register port decode, control register,
// framing engine and buffer/status logic.
// Assumes a synchronous register port with combinational read data and
// a sampling enable supplied by an external rate divider.
module uart_rx_stat
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             rxd,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);

    rx_ctrl_t          ctrl;
    logic              rd_buf;
    logic              wr_stat;
    logic              wr_ctrl;
    logic              run;
    logic              f_done;
    logic [DATA_W-1:0] f_data;
    logic              f_perr;
    logic              f_ferr;
    logic [DATA_W-1:0] buf_q;
    logic              full_q;
    logic              ovr_q;
    logic              pe_q;
    logic              fe_q;
    logic              sum_q;

    // Decode register strobes and the reception gate.
    always_comb begin
        rd_buf  = reg_rd && (reg_addr == ADR_BUF);
        wr_stat = reg_wr && (reg_addr == ADR_STAT);
        wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
        run     = ctrl.ser_en && ctrl.rx_en;
    end

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            ADR_BUF:  reg_rdata = REG_W'(buf_q);
            ADR_STAT: reg_rdata = {3'b111, sum_q, fe_q, pe_q, ovr_q, full_q};
            ADR_CTRL: reg_rdata = ctrl;
            default:  reg_rdata = '0;
        endcase
    end

    uart_rx_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (reg_wdata),
        .ctrl_o  (ctrl)
    );

    uart_rx_frame #(.OSR(OSR), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .smp_en  (smp_en),
        .rxd     (rxd),
        .char7   (ctrl.char7),
        .par_en  (ctrl.par_en),
        .par_odd (ctrl.par_odd),
        .stop2   (ctrl.stop2),
        .done_o  (f_done),
        .data_o  (f_data),
        .perr_o  (f_perr),
        .ferr_o  (f_ferr)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_en_i  (ctrl.ser_en),
        .done_i    (f_done),
        .data_i    (f_data),
        .perr_i    (f_perr),
        .ferr_i    (f_ferr),
        .rd_buf_i  (rd_buf),
        .wr_stat_i (wr_stat),
        .buf_o     (buf_q),
        .full_o    (full_q),
        .ovr_o     (ovr_q),
        .pe_o      (pe_q),
        .fe_o      (fe_q),
        .sum_o     (sum_q)
    );

    // R11: no character completes while reception is gated off
    p_no_rx_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !f_done);

endmodule

// File: tb/tb_uart_rx_stat.sv
// Directed bench for the serial receiver: one task per scenario.
module tb_uart_rx_stat;

    localparam int OSR     = 16;
    localparam int TICKDIV = 2;
    localparam int BITCYC  = OSR * TICKDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_en = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int tick_cnt = 0;

    uart_rx_stat #(.OSR(OSR), .DATA_W(8)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_en    (smp_en),
        .rxd       (rxd),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #10 clk = ~clk;

    // Sampling enable: one pulse every TICKDIV clocks.
    always @(negedge clk) begin
        smp_en   <= (tick_cnt == 0);
        tick_cnt <= (tick_cnt == TICKDIV - 1) ? 0 : tick_cnt + 1;
    end

    task automatic check(input string req, input [7:0] act, input [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input [1:0] a, input [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input [1:0] a, output [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop_buf(output [7:0] d);
        @(negedge clk);
        reg_addr = 2'd0; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic line_bit(input bit v);
        @(negedge clk);
        rxd = v;
        repeat (BITCYC - 1) @(negedge clk);
    endtask

    // Send one frame; bad_par flips the parity bit.
    task automatic send(input [7:0] d, input int nb, input bit use_par,
                        input bit odd, input bit bad_par, input bit s1,
                        input bit two, input bit s2);
        bit p;
        p = odd;
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            line_bit(d[i]);
            p ^= d[i];
        end
        if (use_par) line_bit(p ^ bad_par);
        line_bit(s1);
        if (two) line_bit(s2);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd1, v); check("R1 status after reset", v, 8'hE0);
        rd_reg(2'd2, v); check("R1 control after reset", v, 8'h00);
    endtask

    task automatic t_eight_bit;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC0);
        send(8'hA5, 8, 0, 0, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R2 full after 0xA5", v, 8'hE1);
        pop_buf(v);      check("R2 data 0xA5", v, 8'hA5);
        rd_reg(2'd1, v); check("R6 full cleared by read", v, 8'hE0);
        send(8'h3C, 8, 0, 0, 0, 1, 0, 1);
        pop_buf(v);      check("R2 data 0x3C", v, 8'h3C);
    endtask

    task automatic t_seven_bit;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC1);
        send(8'h7F, 7, 0, 0, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R3 full after 7-bit", v, 8'hE1);
        pop_buf(v);      check("R3 7-bit data with MSB 0", v, 8'h7F);
    endtask

    task automatic t_parity;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC2);
        send(8'h5B, 8, 1, 0, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R4 even parity good", v, 8'hE1);
        pop_buf(v);      check("R4 parity bit not stored", v, 8'h5B);
        send(8'h5A, 8, 1, 0, 1, 1, 0, 1);
        rd_reg(2'd1, v); check("R4 R8 even parity bad", v, 8'hF5);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, v); check("R9 status write clears errors only", v, 8'hE1);
        pop_buf(v);
        wr_reg(2'd2, 8'hC6);
        send(8'h01, 8, 1, 1, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R4 odd parity good", v, 8'hE1);
        pop_buf(v);
        send(8'h03, 8, 1, 1, 1, 1, 0, 1);
        rd_reg(2'd1, v); check("R4 odd parity bad", v, 8'hF5);
        wr_reg(2'd1, 8'hFF);
        pop_buf(v);
    endtask

    task automatic t_framing;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC0);
        send(8'h11, 8, 0, 0, 0, 0, 0, 1);
        rd_reg(2'd1, v); check("R5 R8 framing error", v, 8'hF9);
        pop_buf(v);      check("R5 data kept on framing error", v, 8'h11);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'hC8);
        send(8'h81, 8, 0, 0, 0, 1, 1, 0);
        rd_reg(2'd1, v); check("R5 second stop not checked", v, 8'hE1);
        pop_buf(v);      check("R5 two-stop data", v, 8'h81);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC0);
        send(8'h12, 8, 0, 0, 0, 1, 0, 1);
        send(8'h34, 8, 0, 0, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R7 R8 overrun flagged", v, 8'hF3);
        rd_reg(2'd0, v); check("R7 old data kept", v, 8'h12);
        wr_reg(2'd2, 8'h40);
        rd_reg(2'd1, v); check("R10 disable clears all flags", v, 8'hE0);
    endtask

    task automatic t_gated;
        logic [7:0] v;
        wr_reg(2'd2, 8'h80);
        send(8'h66, 8, 0, 0, 0, 1, 0, 1);
        rd_reg(2'd1, v); check("R11 receive disabled ignores line", v, 8'hE0);
        rd_reg(2'd0, v); check("R11 buffer untouched", v, 8'h12);
    endtask

    task automatic t_noise;
        logic [7:0] v;
        wr_reg(2'd2, 8'hC0);
        @(negedge clk); rxd = 1'b0;
        repeat (3 * TICKDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITCYC) @(negedge clk);
        rd_reg(2'd1, v); check("R12 short pulse ignored", v, 8'hE0);
        send(8'h99, 8, 0, 0, 0, 1, 0, 1);
        pop_buf(v);      check("R12 receive after noise", v, 8'h99);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_eight_bit;
        t_seven_bit;
        t_parity;
        t_framing;
        t_overrun;
        t_gated;
        t_noise;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule